// File: doc/BRIEF.md
# Shared-Pool Register Renamer for Multithreaded Cores

This block sits in the rename stage of a core that runs several hardware threads at once. Each thread has its own small table that maps its architectural registers to physical register tags. Every thread takes new tags from one shared pool of free physical tags. A tag carries no record of which thread owns it, so downstream logic treats every tag the same way.

The front end presents one rename request per cycle on a valid/ready handshake. A request names the thread, two source registers and a destination register, and a bit that says whether the destination is written. In the same cycle the block returns the physical tags of both sources. When a destination is written, it also returns a fresh tag for the destination and the tag that was mapped there before.

The earlier tag goes with the instruction. At retirement it comes back through the retire port and is appended to the free pool. The pool is smaller than one full register set per thread would need. When the pool runs dry, the block raises a stall and refuses destination-writing renames until retired tags come back.

Top module: `rn_renamer`

## Requirements
- R1: After reset, architectural register r of thread t maps to physical tag t*8 + r (with the default 8 registers per thread).
- R2: Source tags are read from the requesting thread's own table. A rename in one thread never changes the mapping seen by another thread.
- R3: The free pool is first-in first-out. After reset it holds tags 32 to 255 in ascending order, so the first destination allocated gets tag 32. Each allocation takes the oldest free tag.
- R4: For a destination-writing rename, prevTag is the mapping the destination held before the request. From the next cycle on, sources that name that register in that thread return the new tag.
- R5: When a source names the same register as the destination in the same request, the source returns the old mapping, not the new tag.
- R6: A request with reqDestValid low allocates nothing and leaves all tables unchanged. The next allocation still gets the same head tag.
- R7: stall is high exactly when the free pool is empty. While stall is high, reqReady is low for destination-writing requests, and no table or pool change comes from them.
- R8: A tag presented on the retire port is appended to the pool at the clock edge, even when an allocation happens in the same cycle. A tag retired while the pool is empty can be allocated from the following cycle.
- R9: No physical tag is mapped by two architectural registers at once, in one thread or across threads. A newly allocated tag always differs from the tag it replaces.
- R10: Requests with reqDestValid low are always accepted (reqReady high), even while the pool is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Rename request present |
| reqReady | output | 1 | Request accepted this cycle |
| reqThread | input | 2 | Requesting hardware thread |
| reqSrcA | input | 3 | First source architectural register |
| reqSrcB | input | 3 | Second source architectural register |
| reqDest | input | 3 | Destination architectural register |
| reqDestValid | input | 1 | Request writes a destination |
| srcTagA | output | 8 | Physical tag of first source |
| srcTagB | output | 8 | Physical tag of second source |
| newTag | output | 8 | Tag allocated for the destination (head of free pool) |
| prevTag | output | 8 | Tag the destination held before this request |
| retValid | input | 1 | Retired tag present |
| retTag | input | 8 | Tag returned to the free pool |
| stall | output | 1 | Free pool empty |

## Verification
The assertions check several things on every cycle against a free-tag count kept in the checker:
- stall matches that count, and reqReady is low for destination requests while stall is high;
- requests without a destination are always accepted;
- a retire never overflows the pool;
- when a source names the destination, it reads the old mapping;
- a rename is visible to the next request of the same thread;
- the head tag holds still when nothing pops, and a new tag never equals the one it replaces.

Only the bench's scenarios can show the rest:
- the reset mapping;
- the exact first-in first-out order of tags through a full drain and refill;
- the allocation of a tag that was retired into an empty pool;
- the independence of threads;
- the global uniqueness of all mappings after thousands of mixed random renames and retirements.

// File: rtl/rn_pkg.sv
package rn_pkg;

  // Strobes sent from control to datapath for one cycle
  typedef struct packed {
    logic mapWrite;   // update the requesting thread's map entry
    logic popFree;    // consume the head of the free pool
    logic pushFree;   // append the retired tag at the tail
  } rnStrobesT;

endpackage

// File: rtl/rn_map_bank.sv
// One thread's architectural-to-physical map table.
module rn_map_bank #(
  parameter int ARCH_REGS = 8,
  parameter int TAG_W     = 8,
  parameter int BASE_TAG  = 0,
  localparam int IDX_W    = $clog2(ARCH_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [TAG_W-1:0] wrTag,
  input  logic [IDX_W-1:0] rdIdxA,
  input  logic [IDX_W-1:0] rdIdxB,
  input  logic [IDX_W-1:0] rdIdxD,
  output logic [TAG_W-1:0] rdTagA,
  output logic [TAG_W-1:0] rdTagB,
  output logic [TAG_W-1:0] rdTagD
);

  logic [TAG_W-1:0] mapTbl [ARCH_REGS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ARCH_REGS; r++) begin
        mapTbl[r] <= TAG_W'(BASE_TAG + r);
      end
    end else if (wrEn) begin
      mapTbl[wrIdx] <= wrTag;
    end
  end

  // Reads see the table before this cycle's write (old mapping)
  assign rdTagA = mapTbl[rdIdxA];
  assign rdTagB = mapTbl[rdIdxB];
  assign rdTagD = mapTbl[rdIdxD];

endmodule

// File: rtl/rn_ctrl.sv
// Handshake, stall and free-pool pointer bookkeeping.
module rn_ctrl
  import rn_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int ARCH_REGS   = 8,
  parameter int PHYS_REGS   = 256,
  localparam int PTR_W      = $clog2(PHYS_REGS),
  localparam int CNT_W      = $clog2(PHYS_REGS + 1),
  localparam int INIT_FREE  = PHYS_REGS - NUM_THREADS * ARCH_REGS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqDestValid,
  input  logic             retValid,
  output logic             reqReady,
  output logic             stall,
  output rnStrobesT        strobes,
  output logic [PTR_W-1:0] headPtr,
  output logic [PTR_W-1:0] tailPtr
);

  logic [CNT_W-1:0] freeCnt;
  logic             poolEmpty;
  logic             doAlloc;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (32'(p) == PHYS_REGS - 1) ? '0 : p + 1'b1;
  endfunction

  assign poolEmpty = (freeCnt == '0);
  assign stall     = poolEmpty;
  assign reqReady  = rstN && !(reqDestValid && poolEmpty);
  assign doAlloc   = reqValid && reqReady && reqDestValid;

  always_comb begin
    strobes          = '0;
    strobes.mapWrite = doAlloc;
    strobes.popFree  = doAlloc;
    strobes.pushFree = retValid && rstN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeCnt <= CNT_W'(INIT_FREE);
      headPtr <= '0;
      tailPtr <= PTR_W'(INIT_FREE % PHYS_REGS);
    end else begin
      if (strobes.popFree)  headPtr <= nextPtr(headPtr);
      if (strobes.pushFree) tailPtr <= nextPtr(tailPtr);
      case ({strobes.popFree, strobes.pushFree})
        2'b10:   freeCnt <= freeCnt - 1'b1;
        2'b01:   freeCnt <= freeCnt + 1'b1;
        default: freeCnt <= freeCnt;
      endcase
    end
  end

endmodule

// File: rtl/rn_datapath.sv
// Per-thread map banks plus the shared free-tag FIFO storage.
module rn_datapath
  import rn_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int ARCH_REGS   = 8,
  parameter int PHYS_REGS   = 256,
  localparam int TAG_W      = $clog2(PHYS_REGS),
  localparam int PTR_W      = $clog2(PHYS_REGS),
  localparam int IDX_W      = $clog2(ARCH_REGS),
  localparam int THR_W      = $clog2(NUM_THREADS),
  localparam int MAPPED     = NUM_THREADS * ARCH_REGS
) (
  input  logic             clk,
  input  logic             rstN,
  input  rnStrobesT        strobes,
  input  logic [PTR_W-1:0] headPtr,
  input  logic [PTR_W-1:0] tailPtr,
  input  logic [THR_W-1:0] reqThread,
  input  logic [IDX_W-1:0] reqSrcA,
  input  logic [IDX_W-1:0] reqSrcB,
  input  logic [IDX_W-1:0] reqDest,
  input  logic [TAG_W-1:0] retTag,
  output logic [TAG_W-1:0] srcTagA,
  output logic [TAG_W-1:0] srcTagB,
  output logic [TAG_W-1:0] newTag,
  output logic [TAG_W-1:0] prevTag
);

  logic [TAG_W-1:0] freeMem [PHYS_REGS];
  logic [TAG_W-1:0] bankA [NUM_THREADS];
  logic [TAG_W-1:0] bankB [NUM_THREADS];
  logic [TAG_W-1:0] bankD [NUM_THREADS];

  assign newTag = freeMem[headPtr];

  // Shared free pool: reset content is every tag not in an initial map
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PHYS_REGS; i++) begin
        freeMem[i] <= (i < PHYS_REGS - MAPPED) ? TAG_W'(i + MAPPED) : '0;
      end
    end else if (strobes.pushFree) begin
      freeMem[tailPtr] <= retTag;
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : gThread
    logic selThis;
    assign selThis = strobes.mapWrite && (32'(reqThread) == t);

    rn_map_bank #(
      .ARCH_REGS(ARCH_REGS),
      .TAG_W    (TAG_W),
      .BASE_TAG (t * ARCH_REGS)
    ) uBank (
      .clk   (clk),
      .rstN  (rstN),
      .wrEn  (selThis),
      .wrIdx (reqDest),
      .wrTag (newTag),
      .rdIdxA(reqSrcA),
      .rdIdxB(reqSrcB),
      .rdIdxD(reqDest),
      .rdTagA(bankA[t]),
      .rdTagB(bankB[t]),
      .rdTagD(bankD[t])
    );
  end

  assign srcTagA = bankA[reqThread];
  assign srcTagB = bankB[reqThread];
  assign prevTag = bankD[reqThread];

endmodule

// File: rtl/rn_renamer.sv
// Top: rename stage with per-thread maps and one shared tag pool.
module rn_renamer
  import rn_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int ARCH_REGS   = 8,
  parameter int PHYS_REGS   = 256,
  localparam int TAG_W      = $clog2(PHYS_REGS),
  localparam int PTR_W      = $clog2(PHYS_REGS),
  localparam int IDX_W      = $clog2(ARCH_REGS),
  localparam int THR_W      = $clog2(NUM_THREADS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [THR_W-1:0] reqThread,
  input  logic [IDX_W-1:0] reqSrcA,
  input  logic [IDX_W-1:0] reqSrcB,
  input  logic [IDX_W-1:0] reqDest,
  input  logic             reqDestValid,
  output logic [TAG_W-1:0] srcTagA,
  output logic [TAG_W-1:0] srcTagB,
  output logic [TAG_W-1:0] newTag,
  output logic [TAG_W-1:0] prevTag,
  input  logic             retValid,
  input  logic [TAG_W-1:0] retTag,
  output logic             stall
);

  rnStrobesT        strobes;
  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;

  rn_ctrl #(
    .NUM_THREADS(NUM_THREADS),
    .ARCH_REGS  (ARCH_REGS),
    .PHYS_REGS  (PHYS_REGS)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqDestValid(reqDestValid),
    .retValid    (retValid),
    .reqReady    (reqReady),
    .stall       (stall),
    .strobes     (strobes),
    .headPtr     (headPtr),
    .tailPtr     (tailPtr)
  );

  rn_datapath #(
    .NUM_THREADS(NUM_THREADS),
    .ARCH_REGS  (ARCH_REGS),
    .PHYS_REGS  (PHYS_REGS)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .headPtr  (headPtr),
    .tailPtr  (tailPtr),
    .reqThread(reqThread),
    .reqSrcA  (reqSrcA),
    .reqSrcB  (reqSrcB),
    .reqDest  (reqDest),
    .retTag   (retTag),
    .srcTagA  (srcTagA),
    .srcTagB  (srcTagB),
    .newTag   (newTag),
    .prevTag  (prevTag)
  );

endmodule

// File: rtl/rn_renamer_chk.sv
// Property checker bound to rn_renamer.
module rn_renamer_chk #(
  parameter int NUM_THREADS = 4,
  parameter int ARCH_REGS   = 8,
  parameter int PHYS_REGS   = 256,
  localparam int TAG_W      = $clog2(PHYS_REGS),
  localparam int IDX_W      = $clog2(ARCH_REGS),
  localparam int THR_W      = $clog2(NUM_THREADS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [THR_W-1:0] reqThread,
  input logic [IDX_W-1:0] reqSrcA,
  input logic [IDX_W-1:0] reqSrcB,
  input logic [IDX_W-1:0] reqDest,
  input logic             reqDestValid,
  input logic [TAG_W-1:0] srcTagA,
  input logic [TAG_W-1:0] srcTagB,
  input logic [TAG_W-1:0] newTag,
  input logic [TAG_W-1:0] prevTag,
  input logic             retValid,
  input logic [TAG_W-1:0] retTag,
  input logic             stall
);

  logic             fire;
  int               shadowCnt;
  logic             lastFire;
  logic [THR_W-1:0] lastThread;
  logic [IDX_W-1:0] lastDest;
  logic [TAG_W-1:0] lastTag;
  logic             lastHeld;

  assign fire = reqValid && reqReady && reqDestValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCnt  <= PHYS_REGS - NUM_THREADS * ARCH_REGS;
      lastFire   <= 1'b0;
      lastThread <= '0;
      lastDest   <= '0;
      lastTag    <= '0;
      lastHeld   <= 1'b0;
    end else begin
      shadowCnt  <= shadowCnt - (fire ? 1 : 0) + (retValid ? 1 : 0);
      lastFire   <= fire;
      lastThread <= reqThread;
      lastDest   <= reqDest;
      lastTag    <= newTag;
      lastHeld   <= !fire && !stall;
    end
  end

  // R7
  stall_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall == (shadowCnt == 0));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stall && reqValid && reqDestValid) |-> !reqReady);

  // R10
  nodest_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqDestValid) |-> reqReady);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    retValid |-> (shadowCnt < PHYS_REGS));

  // R5
  same_reg_old_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqDestValid && reqSrcA == reqDest) |-> (srcTagA == prevTag));

  // R4
  rename_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastFire && reqValid && reqThread == lastThread && reqSrcB == lastDest)
      |-> (srcTagB == lastTag));

  // R6
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastHeld |-> (newTag == lastTag));

  // R9
  fresh_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> (newTag != prevTag));

endmodule

bind rn_renamer rn_renamer_chk #(
  .NUM_THREADS(NUM_THREADS),
  .ARCH_REGS  (ARCH_REGS),
  .PHYS_REGS  (PHYS_REGS)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqThread   (reqThread),
  .reqSrcA     (reqSrcA),
  .reqSrcB     (reqSrcB),
  .reqDest     (reqDest),
  .reqDestValid(reqDestValid),
  .srcTagA     (srcTagA),
  .srcTagB     (srcTagB),
  .newTag      (newTag),
  .prevTag     (prevTag),
  .retValid    (retValid),
  .retTag      (retTag),
  .stall       (stall)
);

// File: tb/rn_renamer_test.sv
module rn_renamer_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       reqValid, reqReady, reqDestValid, retValid, stall;
  logic [1:0] reqThread;
  logic [2:0] reqSrcA, reqSrcB, reqDest;
  logic [7:0] srcTagA, srcTagB, newTag, prevTag, retTag;

  int checks = 0;
  int errors = 0;

  // Bench model
  int mapM [4][8];
  int freeQ [256];
  int fh, ft, fc;
  int pendQ [256];
  int ph, pt, pc;
  int lastNew;

  always #10 clk = ~clk;

  rn_renamer uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqThread(reqThread), .reqSrcA(reqSrcA), .reqSrcB(reqSrcB),
    .reqDest(reqDest), .reqDestValid(reqDestValid), .srcTagA(srcTagA),
    .srcTagB(srcTagB), .newTag(newTag), .prevTag(prevTag),
    .retValid(retValid), .retTag(retTag), .stall(stall)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p == 255) ? 0 : p + 1;
  endfunction

  task automatic modelReset();
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 8; r++) mapM[t][r] = t * 8 + r;
    for (int i = 0; i < 224; i++) freeQ[i] = 32 + i;
    fh = 0; ft = 224; fc = 224;
    ph = 0; pt = 0; pc = 0;
  endtask

  // One cycle: drive at negedge, check combinational outputs, update model
  task automatic step(input bit v, input int th, input int a, input int b,
                      input int d, input bit dv, input bit rv, input int rt,
                      input string req);
    bit expReady;
    @(negedge clk);
    reqValid = v; reqThread = 2'(th); reqSrcA = 3'(a); reqSrcB = 3'(b);
    reqDest = 3'(d); reqDestValid = dv; retValid = rv; retTag = 8'(rt);
    #2;
    expReady = !(dv && fc == 0);
    chk("R7 stall", int'(stall), (fc == 0) ? 1 : 0);
    lastNew = int'(newTag);
    if (v) begin
      chk(dv ? "R7 ready" : "R10 ready", int'(reqReady), int'(expReady));
      chk(req, int'(srcTagA), mapM[th][a]);
      chk(req, int'(srcTagB), mapM[th][b]);
      if (dv && expReady) begin
        chk("R3 newTag", int'(newTag), freeQ[fh]);
        chk("R4 prevTag", int'(prevTag), mapM[th][d]);
        pendQ[pt] = mapM[th][d]; pt = nxt(pt); pc++;
        mapM[th][d] = freeQ[fh]; fh = nxt(fh); fc--;
      end
    end
    if (rv) begin
      freeQ[ft] = rt; ft = nxt(ft); fc++;
    end
  endtask

  task automatic idle();
    step(1'b0, 0, 0, 0, 0, 1'b0, 1'b0, 0, "idle");
  endtask

  function automatic int popPend();
    int v;
    v = pendQ[ph]; ph = nxt(ph); pc--;
    return v;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int rt;
    bit seen [256];
    void'($urandom(32'd1234));
    rstN = 1'b0;
    reqValid = 0; reqDestValid = 0; retValid = 0; retTag = 0;
    reqThread = 0; reqSrcA = 0; reqSrcB = 0; reqDest = 0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset mapping read through sources with no destination
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 8; r++)
        step(1'b1, t, r, 7 - r, 0, 1'b0, 1'b0, 0, "R1 reset map");

    // R6: no-destination request leaves the head tag in place
    step(1'b1, 2, 1, 2, 3, 1'b0, 1'b0, 0, "R6");
    chk("R6 head", lastNew, 32);

    // R5: source equals destination reads old mapping
    step(1'b1, 0, 3, 3, 3, 1'b1, 1'b0, 0, "R5 src==dest");
    chk("R3 first alloc", lastNew, 32);
    // R4: new mapping visible next cycle; R2: other thread untouched
    step(1'b1, 0, 3, 1, 5, 1'b0, 1'b0, 0, "R4 visible");
    step(1'b1, 1, 3, 3, 0, 1'b0, 1'b0, 0, "R2 thread independent");
    chk("R2 thread1 r3", mapM[1][3], 11);

    // Drain the pool (223 tags left)
    for (int i = 0; i < 223; i++)
      step(1'b1, i % 4, i % 8, (i + 3) % 8, (i * 5) % 8, 1'b1, 1'b0, 0, "R3 drain");
    idle();
    chk("R7 empty model", fc, 0);
    step(1'b1, 1, 0, 1, 2, 1'b1, 1'b0, 0, "R7 blocked");
    step(1'b1, 2, 4, 5, 6, 1'b0, 1'b0, 0, "R10 nodest while empty");
    // R8: retire together with a blocked allocate
    rt = popPend();
    step(1'b1, 3, 1, 2, 4, 1'b1, 1'b1, rt, "R8 retire on empty");
    step(1'b1, 3, 1, 2, 4, 1'b1, 1'b0, 0, "R8 alloc retired");
    chk("R8 reused tag", lastNew, rt);
    // R8: retire and allocate in the same cycle with a non-empty pool
    rt = popPend();
    step(1'b1, 0, 0, 0, 1, 1'b0, 1'b1, rt, "R8 refill");
    rt = popPend();
    step(1'b1, 1, 2, 3, 4, 1'b1, 1'b1, rt, "R8 alloc+retire");
    step(1'b1, 1, 4, 4, 5, 1'b1, 1'b0, 0, "R8 after both");

    // Random mix of renames and retirements
    for (int i = 0; i < 4000; i++) begin
      bit v, dv, rv;
      v  = ($urandom % 4) != 0;
      dv = ($urandom % 4) != 0;
      rv = (pc > 0) && (($urandom % 2) == 0);
      rt = rv ? popPend() : 0;
      step(v, $urandom % 4, $urandom % 8, $urandom % 8, $urandom % 8,
           dv, rv, rt, "R2 random src");
    end

    // R9: all live mappings distinct
    for (int i = 0; i < 256; i++) seen[i] = 1'b0;
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 8; r++) begin
        step(1'b1, t, r, r, 0, 1'b0, 1'b0, 0, "R9 readout");
        chk("R9 unique", int'(seen[srcTagA]), 0);
        seen[srcTagA] = 1'b1;
      end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule